// File: doc/BRIEF.md
# Dual audio clock divider

This block produces two independent pairs of serial-audio clocks, each pair being a bit clock and a frame (left/right) clock. Everything runs on a single 24.576 MHz reference `clk`. The master clock that feeds the dividers is either that reference (full rate) or half of it, 12.288 MHz. The half rate is made as a tick enable, not as a second clock. Each pair has its own 2-bit bit-rate code and its own 2-bit frame-rate code, so the two pairs can run at different rates at the same time.

One master tick counter, `CNT_W` bits wide, is shared by both pairs. Each output is a registered copy of one counter bit, chosen from the rate code and the master rate. This keeps every frame clock edge on a bit clock falling edge. New rate codes are taken only when the counter wraps, which happens every 2^CNT_W master ticks. A request to change the master rate waits a programmable number of wraps before it takes effect. A clock therefore never shows a shortened phase when its settings change.

When `run` is low, the counter is cleared and every output sits at its idle level. Codes and the master-rate request are then taken directly. No data flows through the block, so all pins are plain level controls.

Top module: `dual_aclk_div`

## Requirements
- R1: With the master at full rate, bit code 00 gives a bit clock period of 8 `clk` cycles (3.072 MHz), code 01 gives 4 cycles (6.144 MHz) and code 10 gives 2 cycles (12.288 MHz).
- R2: Frame code 00 gives a frame clock period of 512 `clk` cycles (48 kHz), code 01 gives 256 (96 kHz) and code 10 gives 128 (192 kHz), at either master rate.
- R3: Code 11 mutes the output it selects. A muted bit clock stays low and a muted frame clock stays high.
- R4: With the master at half rate (`mclk_half` = 1 in effect), bit code 10 falls back to an 8-cycle period (3.072 MHz). Codes 00 and 01 keep their R1 periods.
- R5: During reset and in the cycle after `run` is sampled low, both bit clocks are low and both frame clocks are high.
- R6: The two pairs follow their own codes, and may run at different rates at the same time.
- R7: A frame clock never changes level unless its bit clock is low after that same edge. When both run, each frame clock edge coincides with a bit clock falling edge.
- R8: While running, new rate codes are taken only at a counter wrap. No high or low phase of a running output is shorter than the smaller of its old and new half-periods.
- R9: While running, a change of `mclk_half` takes effect at the (`src_wait`+1)-th counter wrap after the request appears. If the request returns to the value in effect, the wait restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Dividers run when high; idle and cleared when low |
| mclk_half | input | 1 | Requested master rate: 0 full (24.576 MHz), 1 half (12.288 MHz) |
| src_wait | input | WAIT_W (2) | Number of extra counter wraps before a master-rate change takes effect |
| bit_sel0 | input | 2 | Bit-rate code, pair 0 |
| frm_sel0 | input | 2 | Frame-rate code, pair 0 |
| bit_sel1 | input | 2 | Bit-rate code, pair 1 |
| frm_sel1 | input | 2 | Frame-rate code, pair 1 |
| bit_clk0 | output | 1 | Bit clock, pair 0 |
| frm_clk0 | output | 1 | Frame clock, pair 0 |
| bit_clk1 | output | 1 | Bit clock, pair 1 |
| frm_clk1 | output | 1 | Frame clock, pair 1 |

## Verification
The hardest case to reach from the pins is the timing of the master-rate wait, because the counter wrap is internal and a rate change does not alter most output periods. The stimulus sets pair 0 to 48 kHz, whose rising frame edge at full rate marks each wrap. It then issues the request just after such an edge. Pair 1 runs bit code 10, so the change shows up as the clamp turning its 2-cycle bit clock into an 8-cycle one. The bench counts the wrap markers up to that point and compares the count with `src_wait`+1. A separate probe changes codes away from any wrap and measures every phase across the change, to catch truncated phases.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // two-bit rate selection shared by bit and frame clocks
  typedef logic [1:0] rate_code_t;

  localparam rate_code_t RATE_LOW  = 2'b00;
  localparam rate_code_t RATE_MID  = 2'b01;
  localparam rate_code_t RATE_HIGH = 2'b10;
  localparam rate_code_t RATE_MUTE = 2'b11;

endpackage

// File: rtl/aclk_tick_gen.sv
module aclk_tick_gen #(
  parameter int CNT_W  = 9,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              half_req,
  input  logic [WAIT_W-1:0] wait_sel,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap,
  output logic              half_act
);

  logic              phase;
  logic              tick;
  logic [WAIT_W-1:0] wcnt;

  // master tick: every reference cycle at full rate, every second one at half rate
  assign tick = !half_act || phase;
  assign wrap = run && tick && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      cnt      <= '0;
      half_act <= 1'b0;
      wcnt     <= '0;
    end else if (!run) begin
      phase    <= 1'b0;
      cnt      <= '0;
      half_act <= half_req;
      wcnt     <= '0;
    end else begin
      phase <= half_act ? !phase : 1'b0;
      if (tick) begin
        cnt <= cnt + 1'b1;
      end
      if (wrap) begin
        if (half_req != half_act) begin
          if (wcnt == wait_sel) begin
            half_act <= half_req;
            wcnt     <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end else begin
          wcnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/aclk_set.sv
module aclk_set
  import aclk_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int BCK_TOP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic             half,
  input  logic [CNT_W-1:0] cnt,
  input  rate_code_t       bit_sel,
  input  rate_code_t       frm_sel,
  output rate_code_t       cfg_bit,
  output rate_code_t       cfg_frm,
  output logic             bit_clk,
  output logic             frm_clk
);

  localparam int IDX_W = $clog2(CNT_W);
  localparam logic [IDX_W-1:0] BTOP = IDX_W'(BCK_TOP);
  localparam logic [IDX_W-1:0] FTOP = IDX_W'(CNT_W - 1);

  logic [IDX_W-1:0] bidx;
  logic [IDX_W-1:0] fidx;
  logic             b_next;
  logic             f_next;

  // codes are taken only at a counter wrap, or freely while stopped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_bit <= RATE_LOW;
      cfg_frm <= RATE_LOW;
    end else if (!run || wrap) begin
      cfg_bit <= bit_sel;
      cfg_frm <= frm_sel;
    end
  end

  // counter bit selection; a half-rate master moves every index down by one
  always_comb begin
    unique case (cfg_bit)
      RATE_MID:  bidx = BTOP - IDX_W'(1);
      RATE_HIGH: bidx = half ? BTOP : BTOP - IDX_W'(2);
      default:   bidx = BTOP;
    endcase
    if (half) begin
      bidx = bidx - IDX_W'(1);
    end
    fidx = FTOP - IDX_W'(cfg_frm) - IDX_W'(half);
  end

  assign b_next = run && (cfg_bit != RATE_MUTE) && cnt[bidx];
  assign f_next = !(run && (cfg_frm != RATE_MUTE)) || !cnt[fidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_clk <= 1'b0;
      frm_clk <= 1'b1;
    end else begin
      bit_clk <= b_next;
      frm_clk <= f_next;
    end
  end

endmodule

// File: rtl/dual_aclk_div.sv
module dual_aclk_div
  import aclk_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int BCK_TOP = 2,
  parameter int WAIT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mclk_half,
  input  logic [WAIT_W-1:0] src_wait,
  input  logic [1:0]        bit_sel0,
  input  logic [1:0]        frm_sel0,
  input  logic [1:0]        bit_sel1,
  input  logic [1:0]        frm_sel1,
  output logic              bit_clk0,
  output logic              frm_clk0,
  output logic              bit_clk1,
  output logic              frm_clk1
);

  localparam int NSET = 2;

  logic [CNT_W-1:0]      cnt;
  logic                  wrap;
  logic                  src_half;
  logic [NSET-1:0][1:0]  bsel_v;
  logic [NSET-1:0][1:0]  fsel_v;
  logic [NSET-1:0][1:0]  cfg_b;
  logic [NSET-1:0][1:0]  cfg_f;
  logic [NSET-1:0]       bclk_v;
  logic [NSET-1:0]       fclk_v;

  assign bsel_v = {bit_sel1, bit_sel0};
  assign fsel_v = {frm_sel1, frm_sel0};

  aclk_tick_gen #(
    .CNT_W  (CNT_W),
    .WAIT_W (WAIT_W)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_req (mclk_half),
    .wait_sel (src_wait),
    .cnt      (cnt),
    .wrap     (wrap),
    .half_act (src_half)
  );

  for (genvar i = 0; i < NSET; i++) begin : g_set
    aclk_set #(
      .CNT_W   (CNT_W),
      .BCK_TOP (BCK_TOP)
    ) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .wrap    (wrap),
      .half    (src_half),
      .cnt     (cnt),
      .bit_sel (bsel_v[i]),
      .frm_sel (fsel_v[i]),
      .cfg_bit (cfg_b[i]),
      .cfg_frm (cfg_f[i]),
      .bit_clk (bclk_v[i]),
      .frm_clk (fclk_v[i])
    );
  end

  assign bit_clk0 = bclk_v[0];
  assign frm_clk0 = fclk_v[0];
  assign bit_clk1 = bclk_v[1];
  assign frm_clk1 = fclk_v[1];

endmodule

// File: rtl/dual_aclk_div_chk.sv
module dual_aclk_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       wrap,
  input logic       src_half,
  input logic [1:0] cfg_b0,
  input logic [1:0] cfg_f0,
  input logic [1:0] cfg_b1,
  input logic [1:0] cfg_f1,
  input logic       bit_clk0,
  input logic       frm_clk0,
  input logic       bit_clk1,
  input logic       frm_clk1
);

  // R5
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bit_clk0 && frm_clk0 && !bit_clk1 && frm_clk1));

  // R3
  bit_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_b0 == 2'b11) |=> !bit_clk0);

  // R3
  frm_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_f1 == 2'b11) |=> frm_clk1);

  // R7
  frm_rise_align0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_clk0) |-> !bit_clk0);

  // R7
  frm_fall_align1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_clk1) |-> !bit_clk1);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable({cfg_b0, cfg_f0, cfg_b1, cfg_f1}));

  // R9
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(src_half));

endmodule

bind dual_aclk_div dual_aclk_div_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .wrap     (wrap),
  .src_half (src_half),
  .cfg_b0   (cfg_b[0]),
  .cfg_f0   (cfg_f[0]),
  .cfg_b1   (cfg_b[1]),
  .cfg_f1   (cfg_f[1]),
  .bit_clk0 (bit_clk0),
  .frm_clk0 (frm_clk0),
  .bit_clk1 (bit_clk1),
  .frm_clk1 (frm_clk1)
);

// File: tb/test_dual_aclk_div.sv
`timescale 1ns/1ps
module test_dual_aclk_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       mclk_half = 1'b0;
  logic [1:0] src_wait = 2'd0;
  logic [1:0] bit_sel0 = 2'd0;
  logic [1:0] frm_sel0 = 2'd0;
  logic [1:0] bit_sel1 = 2'd0;
  logic [1:0] frm_sel1 = 2'd0;
  logic       bit_clk0, frm_clk0, bit_clk1, frm_clk1;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  typedef struct {
    int s;
    int bper;
    int fper;
    bit clamp;
    bit indep;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;

  dual_aclk_div i_dual_aclk_div (
    .clk(clk), .rst_n(rst_n), .run(run), .mclk_half(mclk_half), .src_wait(src_wait),
    .bit_sel0(bit_sel0), .frm_sel0(frm_sel0), .bit_sel1(bit_sel1), .frm_sel1(frm_sel1),
    .bit_clk0(bit_clk0), .frm_clk0(frm_clk0), .bit_clk1(bit_clk1), .frm_clk1(frm_clk1)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected periods in reference cycles, from R1..R4
  function automatic int exp_bper(logic [1:0] c, bit half);
    case (c)
      2'd0: return 8;
      2'd1: return 4;
      2'd2: return half ? 8 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_fper(logic [1:0] c);
    case (c)
      2'd0: return 512;
      2'd1: return 256;
      2'd2: return 128;
      default: return 0;
    endcase
  endfunction

  // driver: set codes, let them settle, push expectations for both pairs
  task automatic apply(logic [1:0] b0, logic [1:0] f0, logic [1:0] b1, logic [1:0] f1, bit half, bit indep);
    exp_t e;
    @(negedge clk);
    bit_sel0 = b0; frm_sel0 = f0; bit_sel1 = b1; frm_sel1 = f1; mclk_half = half;
    repeat (2200 + 1024 * (int'(src_wait))) @(negedge clk);
    e.s = 0; e.bper = exp_bper(b0, half); e.fper = exp_fper(f0);
    e.clamp = half && (b0 == 2'd2); e.indep = indep;
    q.push_back(e);
    e.s = 1; e.bper = exp_bper(b1, half); e.fper = exp_fper(f1);
    e.clamp = half && (b1 == 2'd2); e.indep = indep;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  function automatic bit pick_b(int s);
    return (s != 0) ? bit_clk1 : bit_clk0;
  endfunction

  function automatic bit pick_f(int s);
    return (s != 0) ? frm_clk1 : frm_clk0;
  endfunction

  task automatic measure(exp_t it);
    int lastb = -1, lastf = -1, perb = 0, perf = 0;
    int badb = 0, badf = 0, bada = 0, rb = 0, rf = 0;
    bit b, f, pb, pf, bhi = 0, flo = 0;
    string pre;
    pre = it.indep ? "R6 " : "";
    pb = pick_b(it.s);
    pf = pick_f(it.s);
    for (int n = 0; n < 1200; n++) begin
      @(negedge clk);
      b = pick_b(it.s);
      f = pick_f(it.s);
      if (b && !pb) begin
        rb++;
        if (lastb >= 0) begin perb = n - lastb; if (perb != it.bper) badb++; end
        lastb = n;
      end
      if (f && !pf) begin
        rf++;
        if (lastf >= 0) begin perf = n - lastf; if (perf != it.fper) badf++; end
        lastf = n;
      end
      if ((f != pf) && !(pb && !b)) bada++;
      if (b) bhi = 1'b1;
      if (!f) flo = 1'b1;
      pb = b;
      pf = f;
    end
    if (it.bper == 0)
      chk(rb == 0 && !bhi, {pre, "R3 bit clock muted low"}, rb, 0);
    else if (it.clamp)
      chk(badb == 0 && perb == it.bper, {pre, "R4 bit clock clamp period"}, perb, it.bper);
    else
      chk(badb == 0 && perb == it.bper, {pre, "R1 bit clock period"}, perb, it.bper);
    if (it.fper == 0)
      chk(rf == 0 && !flo, {pre, "R3 frame clock muted high"}, rf, 0);
    else
      chk(badf == 0 && perf == it.fper, {pre, "R2 frame clock period"}, perf, it.fper);
    if (it.bper != 0 && it.fper != 0)
      chk(bada == 0, "R7 frame edge on bit falling edge", bada, 0);
  endtask

  // monitor: pops expectations and compares against the outputs
  initial begin
    exp_t it;
    forever begin
      wait (q.size() > 0);
      it = q[0];
      measure(it);
      void'(q.pop_front());
    end
  end

  task automatic idle_check(string req);
    chk(!bit_clk0 && frm_clk0 && !bit_clk1 && frm_clk1, req,
        {bit_clk0, frm_clk0, bit_clk1, frm_clk1}, 4'b0101);
  endtask

  task automatic wait_frm0_rise();
    bit p;
    p = frm_clk0;
    forever begin
      @(negedge clk);
      if (frm_clk0 && !p) break;
      p = frm_clk0;
    end
  endtask

  // R9: count wrap markers (pair 0 frame rises at 48 kHz) until pair 1 clamps
  task automatic wait_probe(int w);
    int rises = 0, lowrun = 0, guard = 0;
    bit p;
    @(negedge clk);
    src_wait = 2'(w); mclk_half = 1'b0;
    bit_sel0 = 2'd0; frm_sel0 = 2'd0; bit_sel1 = 2'd2; frm_sel1 = 2'd0;
    repeat (5200) @(negedge clk);
    wait_frm0_rise();
    mclk_half = 1'b1;
    p = frm_clk0;
    while (lowrun < 3 && guard < 6000) begin
      @(negedge clk);
      guard++;
      if (frm_clk0 && !p) rises++;
      p = frm_clk0;
      lowrun = bit_clk1 ? 0 : lowrun + 1;
    end
    chk(rises == w + 1, "R9 wraps before master-rate switch", rises, w + 1);
    @(negedge clk);
    mclk_half = 1'b0;
    repeat (5200) @(negedge clk);
  endtask

  // R8: change codes mid-frame and measure every phase across the change
  task automatic glitch_probe();
    int lb = 0, lf = 0, minb = 1000000, minf = 1000000;
    bit sb = 0, sf = 0, pb, pf;
    wait_frm0_rise();
    repeat (100) @(negedge clk);
    bit_sel0 = 2'd1; frm_sel0 = 2'd1;
    pb = bit_clk0; pf = frm_clk0;
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      if (bit_clk0 != pb) begin if (sb && lb < minb) minb = lb; sb = 1; lb = 1; end
      else lb++;
      if (frm_clk0 != pf) begin if (sf && lf < minf) minf = lf; sf = 1; lf = 1; end
      else lf++;
      pb = bit_clk0; pf = frm_clk0;
    end
    chk(minb >= 2, "R8 shortest bit clock phase", minb, 2);
    chk(minf >= 128, "R8 shortest frame clock phase", minf, 128);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R5 idle during reset");
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    idle_check("R5 idle while stopped");
    run = 1'b1;
    apply(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0);
    apply(2'd1, 2'd1, 2'd2, 2'd2, 1'b0, 1'b1);   // R6: different rates per pair
    apply(2'd2, 2'd2, 2'd1, 2'd0, 1'b0, 1'b1);
    apply(2'd3, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0);   // R3: mute codes
    apply(2'd2, 2'd1, 2'd1, 2'd2, 1'b1, 1'b0);   // R4: half master, clamp on pair 0
    apply(2'd0, 2'd2, 2'd3, 2'd3, 1'b1, 1'b0);
    apply(2'd0, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0);
    glitch_probe();
    for (int w = 0; w < 4; w++) wait_probe(w);
    src_wait = 2'd0;
    apply(2'd1, 2'd2, 2'd0, 2'd0, 1'b0, 1'b1);
    repeat (37) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    idle_check("R5 idle one cycle after stop");
    repeat (30) @(negedge clk);
    idle_check("R5 idle held while stopped");
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule